// File: doc/BRIEF.md
# Watchdog Timer with Timed-Access Protection

This block is a free-running watchdog counter for a small controller. A prescaler derived from the system clock-rate setting (a 2-bit divider and a fast/slow multiplier) advances a counter. When the counter reaches the timeout chosen by a 2-bit select, a sticky timeout flag is set. If reset generation has been enabled, the same expiry also emits a one-cycle system reset request.

Software sees two byte-wide registers. The control register holds the restart bit, the reset-enable bit and the timeout flag. The key register opens a short unlock window.

The restart bit and the reset-enable bit can only change inside that window. The window opens after two key values are written back to back, and it closes after one control write or after three clocks. A stray store therefore cannot disarm the watchdog or hold it off. Clearing the timeout flag needs no unlock.

Top module: `wdt_guard`

## Requirements
- R1: After reset, or while the reset input is held low, the control register reads 0x00 and `rst_req` is 0. The enable, the flag, the counter and the unlock state are all cleared.
- R2: Control register (`addr`=0) layout: bit 0 is restart, bit 1 is reset enable, bit 2 is the timeout flag, and the other bits read 0. The flag becomes 1 exactly T clocks after the clock edge that accepts a restart, where T = P * 2^(BASE_EXP + 3*`tmo_sel`). The flag then stays 1 until software clears it.
- R3: On expiry with the enable set, `rst_req` is 1 for exactly one cycle. That cycle is the first cycle in which the flag reads 1.
- R4: On expiry with the enable clear, the flag is set and `rst_req` stays 0.
- R5: Writing 0xAA and then 0x55 to the key register (`addr`=1) in consecutive cycles opens a window. A control write in any of the next 3 cycles is accepted and updates the enable from bit 1. The first control write closes the window.
- R6: A control write outside a window leaves the enable unchanged and does not restart the counter.
- R7: A window is not opened if a cycle separates the 0xAA and 0x55 writes. A control write in the 4th cycle after the 0x55 write is ignored.
- R8: The restart bit always reads 0. An accepted write with bit 0 set clears the prescaler and the counter.
- R9: A control write with bit 2 = 0 clears the flag without any unlock. Writing bit 2 = 1 never sets it.
- R10: The prescale period is P = 2^(`clk_div` + (`clk_fast` ? 0 : 1)) clocks per count.
- R11: A restart accepted on the expiry edge wins: no flag is set and no pulse occurs, and a fresh period of T begins. A flag clear on the expiry edge loses: the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (key reads 0) |
| tmo_sel | input | 2 | Timeout select |
| clk_div | input | 2 | Clock-rate divider setting |
| clk_fast | input | 1 | Clock multiplier setting, 1 = fast |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Two events can land on one clock edge: an unlocked software restart and the counter's expiry. A flag clear can also land on the expiry edge. The bench times the unlock sequence so that the restart write is sampled exactly on the edge where the count would expire. It then checks that neither the flag nor the reset pulse appears and that a full new period follows. A second run places an ordinary flag-clear write on the expiry edge and expects the flag and the pulse to appear anyway.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic       ADDR_CTRL = 1'b0;
  localparam logic       ADDR_KEY  = 1'b1;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int BIT_RESTART = 0;
  localparam int BIT_ENABLE  = 1;
  localparam int BIT_FLAG    = 2;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_ARMED = 2'd1,
    UL_OPEN  = 2'd2
  } unlock_st_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int WIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic       ctrl_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  import wdt_pkg::*;

  localparam int WW = $clog2(WIN + 1);

  unlock_st_e    st_q, st_d;
  logic [WW-1:0] win_q, win_d;
  logic          upd;

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    win_d = win_q;
    if (key_wr && wdata == KEY_FIRST) begin
      st_d  = UL_ARMED;
      win_d = '0;
    end else begin
      case (st_q)
        UL_ARMED: begin
          if (key_wr && wdata == KEY_SECOND) begin
            st_d  = UL_OPEN;
            win_d = WW'(WIN);
          end else begin
            st_d = UL_IDLE;
          end
        end
        UL_OPEN: begin
          if (ctrl_wr || key_wr || win_q == WW'(1)) begin
            st_d  = UL_IDLE;
            win_d = '0;
          end else begin
            win_d = win_q - WW'(1);
          end
        end
        default: begin
          st_d  = UL_IDLE;
          win_d = '0;
        end
      endcase
    end
  end

  // Clock enable: idle with no key write holds state
  assign upd = key_wr || (st_q != UL_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= UL_IDLE;
      win_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      win_q <= win_d;
    end
  end

  assign open = (st_q == UL_OPEN);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_EXP = 17,
  parameter int STEP_EXP = 3,
  parameter int DIV_W    = 2,
  parameter int SEL_W    = 2,
  localparam int N_SEL   = 1 << SEL_W,
  localparam int CNT_W   = BASE_EXP + STEP_EXP * (N_SEL - 1),
  localparam int PRE_W   = 1 << DIV_W,
  localparam int SH_W    = $clog2(PRE_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             fast,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  logic [PRE_W-1:0] pre_q, pre_d, pre_last;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_last;
  logic [SH_W-1:0]  shift;
  logic [PRE_W:0]   one_sh;
  logic [CNT_W-1:0] lim [N_SEL];
  logic             tick;

  // Terminal count per timeout select
  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    localparam int E = BASE_EXP + STEP_EXP * g;
    assign lim[g] = CNT_W'((64'd1 << E) - 64'd1);
  end

  // Prescale period
  assign shift    = SH_W'(div) + SH_W'(!fast);
  assign one_sh   = (PRE_W + 1)'(1) << shift;
  assign pre_last = PRE_W'(one_sh - (PRE_W + 1)'(1));
  assign tick     = (pre_q == pre_last);
  assign cnt_last = lim[sel];
  assign expire   = tick && (cnt_q == cnt_last) && !restart;

  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (restart) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      pre_d = '0;
      cnt_d = (cnt_q == cnt_last) ? '0 : cnt_q + CNT_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [2:0] wbits,
  input  logic       open,
  input  logic       expire,
  output logic       restart,
  output logic       en,
  output logic       flag,
  output logic       rst_req
);
  import wdt_pkg::*;

  logic en_q, en_d, flag_q, flag_d, req_q, req_d;
  logic prot_ok;

  assign prot_ok = ctrl_wr && open;
  assign restart = prot_ok && wbits[BIT_RESTART];

  always_comb begin
    en_d = prot_ok ? wbits[BIT_ENABLE] : en_q;
    if (expire)                            flag_d = 1'b1;
    else if (ctrl_wr && !wbits[BIT_FLAG])  flag_d = 1'b0;
    else                                   flag_d = flag_q;
    req_d = expire && en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
      req_q  <= req_d;
    end
  end

  assign en      = en_q;
  assign flag    = flag_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_EXP = 17,
  parameter int STEP_EXP = 3,
  parameter int DIV_W    = 2,
  parameter int WIN      = 3,
  localparam int CNT_W   = BASE_EXP + STEP_EXP * 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [1:0]       tmo_sel,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             clk_fast,
  output logic             rst_req
);
  import wdt_pkg::*;

  logic             rst_n_s;
  logic             key_wr, ctrl_wr, open, expire, restart, en, flag;
  logic [CNT_W-1:0] cnt;

  assign key_wr  = wr_en && (addr == ADDR_KEY);
  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);

  wdt_rst_sync u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_s (rst_n_s)
  );

  wdt_unlock #(.WIN(WIN)) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .key_wr  (key_wr),
    .ctrl_wr (ctrl_wr),
    .wdata   (wdata),
    .open    (open)
  );

  wdt_counter #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP),
    .DIV_W    (DIV_W),
    .SEL_W    (2)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .restart (restart),
    .sel     (tmo_sel),
    .div     (clk_div),
    .fast    (clk_fast),
    .expire  (expire),
    .cnt     (cnt)
  );

  wdt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ctrl_wr (ctrl_wr),
    .wbits   (wdata[2:0]),
    .open    (open),
    .expire  (expire),
    .restart (restart),
    .en      (en),
    .flag    (flag),
    .rst_req (rst_req)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr == ADDR_CTRL) begin
      rdata[BIT_ENABLE] = en;
      rdata[BIT_FLAG]   = flag;
    end
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic             flag,
  input logic             en,
  input logic             open,
  input logic             restart,
  input logic             ctrl_wr,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] cnt
);
  // R3: pulse lasts one cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R3: pulse coincides with the flag
  p_pulse_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag);

  // R4: pulse only when enable was set
  p_pulse_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(en));

  // R2: flag holds unless cleared by software
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctrl_wr && !wdata[2])) |=> flag);

  // R6: enable is frozen while the window is closed
  p_locked_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(en));

  // R8: accepted restart zeroes the counter
  p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .rst_req (rst_req),
  .flag    (flag),
  .en      (en),
  .open    (open),
  .restart (restart),
  .ctrl_wr (ctrl_wr),
  .wdata   (wdata),
  .cnt     (cnt)
);

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int BASE = 4;
  localparam int NV   = 8;
  // {sel[24:23], div[22:21], fast[20], T[19:0]}
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 20'd16},
    {2'd0, 2'd0, 1'b0, 20'd32},
    {2'd0, 2'd3, 1'b1, 20'd128},
    {2'd1, 2'd0, 1'b1, 20'd128},
    {2'd1, 2'd2, 1'b0, 20'd1024},
    {2'd2, 2'd0, 1'b1, 20'd1024},
    {2'd2, 2'd1, 1'b1, 20'd2048},
    {2'd3, 2'd0, 1'b1, 20'd8192}
  };

  logic       clk = 1'b0;
  logic       arst_n;
  logic       wr_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] tmo_sel;
  logic [1:0] clk_div;
  logic       clk_fast;
  logic       rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wdt_guard #(.BASE_EXP(BASE)) u_dut (
    .clk      (clk),
    .arst_n   (arst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .tmo_sel  (tmo_sel),
    .clk_div  (clk_div),
    .clk_fast (clk_fast),
    .rst_req  (rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(1'b1, 8'hAA);
    wr(1'b1, 8'h55);
  endtask

  task automatic rd(output logic [7:0] v);
    addr = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int t;
    arst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    tmo_sel = 2'd3; clk_div = 2'd3; clk_fast = 1'b0;
    idle(3);
    rd(v);
    check("R1 ctrl in reset", {24'd0, v}, 32'h00);
    check("R1 rst_req in reset", {31'd0, rst_req}, 32'd0);
    arst_n = 1'b1;
    idle(4);
    rd(v);
    check("R1 ctrl after reset", {24'd0, v}, 32'h00);

    // R6: locked write ignored
    wr(1'b0, 8'h03);
    rd(v);
    check("R6 enable locked", {31'd0, v[1]}, 32'd0);

    // R5 and R8: unlocked write takes effect, restart reads 0
    unlock();
    wr(1'b0, 8'h03);
    rd(v);
    check("R5 enable set", {31'd0, v[1]}, 32'd1);
    check("R8 restart reads 0", {31'd0, v[0]}, 32'd0);

    // R7: late write ignored
    unlock();
    idle(3);
    wr(1'b0, 8'h00);
    rd(v);
    check("R7 late write", {31'd0, v[1]}, 32'd1);

    // R7: gap between keys
    wr(1'b1, 8'hAA); idle(1); wr(1'b1, 8'h55);
    wr(1'b0, 8'h00);
    rd(v);
    check("R7 broken sequence", {31'd0, v[1]}, 32'd1);

    // R5: first control write closes the window
    unlock();
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h00);
    rd(v);
    check("R5 window closes", {31'd0, v[1]}, 32'd1);

    // R2, R3, R10, R9, R5: table walk (restart written on 3rd window cycle)
    for (int i = 0; i < NV; i++) begin
      tmo_sel  = VEC[i][24:23];
      clk_div  = VEC[i][22:21];
      clk_fast = VEC[i][20];
      t        = int'(VEC[i][19:0]);
      wr(1'b0, 8'h02);
      unlock();
      idle(2);
      wr(1'b0, 8'h03);
      idle(t - 1);
      rd(v);
      check("R2 R10 flag before T", {31'd0, v[2]}, 32'd0);
      check("R3 no early pulse", {31'd0, rst_req}, 32'd0);
      idle(1);
      rd(v);
      check("R2 R10 flag at T", {31'd0, v[2]}, 32'd1);
      check("R3 pulse at T", {31'd0, rst_req}, 32'd1);
      idle(1);
      rd(v);
      check("R3 pulse ends", {31'd0, rst_req}, 32'd0);
      check("R2 flag sticky", {31'd0, v[2]}, 32'd1);
      wr(1'b0, 8'h06);
      rd(v);
      check("R9 flag write 1 keeps", {31'd0, v[2]}, 32'd1);
      wr(1'b0, 8'h02);
      rd(v);
      check("R9 flag cleared", {31'd0, v[2]}, 32'd0);
    end

    tmo_sel = 2'd0; clk_div = 2'd0; clk_fast = 1'b1;

    // R4: expiry without enable
    unlock();
    wr(1'b0, 8'h01);
    idle(15);
    rd(v);
    check("R4 flag before T", {31'd0, v[2]}, 32'd0);
    idle(1);
    rd(v);
    check("R4 flag at T", {31'd0, v[2]}, 32'd1);
    check("R4 no pulse", {31'd0, rst_req}, 32'd0);

    // R11: restart on the expiry edge
    wr(1'b0, 8'h00);
    unlock();
    wr(1'b0, 8'h03);
    idle(13);
    unlock();
    wr(1'b0, 8'h03);
    rd(v);
    check("R11 restart wins flag", {31'd0, v[2]}, 32'd0);
    check("R11 restart wins pulse", {31'd0, rst_req}, 32'd0);
    idle(15);
    rd(v);
    check("R11 new period before T", {31'd0, v[2]}, 32'd0);
    idle(1);
    rd(v);
    check("R11 new period at T", {31'd0, v[2]}, 32'd1);

    // R11: clear on the expiry edge loses
    wr(1'b0, 8'h02);
    unlock();
    wr(1'b0, 8'h03);
    idle(15);
    wr(1'b0, 8'h02);
    rd(v);
    check("R11 set beats clear", {31'd0, v[2]}, 32'd1);
    check("R11 pulse with clear", {31'd0, rst_req}, 32'd1);

    // R1: reset mid-run
    arst_n = 1'b0;
    #1;
    rd(v);
    check("R1 ctrl on reset", {24'd0, v}, 32'h00);
    check("R1 rst_req on reset", {31'd0, rst_req}, 32'd0);
    idle(2);
    finish_run();
  end
endmodule